// File: doc/BRIEF.md
# Bank Latch and Memory Decoder

This block is the address-decode glue for a processor that drives the upper address byte (bank bits 16 to 23) on its data bus while the phase-2 clock is low. A transparent latch captures that byte during the low phase and holds it through the high phase. The data bus is then free to carry data.

From the three low latched bank bits the block derives a bank-zero flag. It decodes the full 24-bit effective address into one-hot chip selects for a 512 KB system: RAM, two I/O halves and ROM. It also forms the 19-bit physical RAM address. A wait-request flag marks accesses to the slow I/O and ROM regions, so the clock stretcher can lengthen the cycle.

Selects and the wait request are qualified by the processor's valid-data and valid-program address strobes. Cycles that are not address cycles never enable a device.

Top module: `bank_decoder`

## Requirements
- R1: While `phi2_i` is low the latch is transparent: the latched bank follows `data_i`, visible on `ram_addr_o[18:16]` (= `data_i[2:0]`).
- R2: While `phi2_i` is high the latched bank holds the value present at the rising edge, whatever `data_i` does.
- R3: `bank_zero_o` is 1 exactly when latched bank bits 0, 1 and 2 are all 0; latched bits 3 to 7 have no effect on it or on any other output, so banks $08 and up alias onto $00 to $07.
- R4: In bank zero, addresses with A15..A12 = 4'hC select I/O: `io_lo_cs_o` when A10 = 0, `io_hi_cs_o` when A10 = 1. A11 is ignored, so $C800-$CFFF mirrors $C000-$C7FF.
- R5: In bank zero, addresses $D000-$FFFF assert `rom_cs_o`.
- R6: Every other address selects RAM (`ram_cs_o`), including every address of banks $01 to $07.
- R7: `ram_addr_o` equals {latched bank bits 2..0, A15..A0}.
- R8: `wait_req_o` is 1 exactly when a valid cycle addresses the I/O or ROM region.
- R9: When both `vda_i` and `vpa_i` are 0, no select and no wait request is active. At any time at most one select is active.
- R10: While `rst_ni` is low the latched bank is cleared to $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of the bank latch |
| phi2_i | input | 1 | Phase-2 clock; latch open while low |
| data_i | input | 8 | Processor data bus, carries bank byte in low phase |
| addr_i | input | 16 | Address bits A15..A0 |
| vda_i | input | 1 | Valid data address strobe |
| vpa_i | input | 1 | Valid program address strobe |
| bank_zero_o | output | 1 | Latched bank is $00 (modulo aliasing) |
| ram_addr_o | output | 19 | Physical RAM address |
| ram_cs_o | output | 1 | RAM select |
| io_lo_cs_o | output | 1 | Lower 1 KB I/O select |
| io_hi_cs_o | output | 1 | Upper 1 KB I/O select |
| rom_cs_o | output | 1 | ROM select |
| wait_req_o | output | 1 | Slow-region wait request |

## Verification
The assertions check, on every phase-2 edge, that the latch matches the bus at the rising edge and still holds that value at the falling edge. They also check that selects stay at most one-hot, that no select fires outside valid cycles, that I/O and ROM never appear outside bank zero, and that a wait request comes only with a slow select.

The exact region boundaries need the bench's scenarios to show them: the $BFFF/$C000, $C3FF/$C400 and $CFFF/$D000 edges, the I/O mirror, and aliasing of banks $08 and up. So do the RAM address composition and the reset value.

// File: rtl/bank_decoder_pkg.sv
package bank_decoder_pkg;
  localparam int unsigned BANK_W      = 8;
  localparam int unsigned BANK_SEL_W  = 3;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned RAM_ADDR_W  = BANK_SEL_W + ADDR_W;
  localparam int unsigned IO_SPLIT_BIT = 10;
  localparam logic [3:0]  IO_NIBBLE   = 4'hC;

  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_IO  = 2'd1,
    REG_ROM = 2'd2
  } region_e;

  typedef struct packed {
    logic ram;
    logic io_lo;
    logic io_hi;
    logic rom;
  } sel_t;
endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         phi2_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] bank_o
);
  logic [W-1:0] bank_q;

  always_latch begin
    if (!rst_ni)      bank_q <= '0;
    else if (!phi2_i) bank_q <= data_i;
  end

  assign bank_o = bank_q;

  // checker state: value captured at rising edge, compared at falling edge
  logic [W-1:0] held_q;
  logic         held_v;
  always_ff @(posedge phi2_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      held_v <= 1'b0;
    end else begin
      held_q <= data_i;
      held_v <= 1'b1;
    end
  end

  p_open_low_r1: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    bank_q == data_i);

  p_hold_high_r2: assert property (@(negedge phi2_i) disable iff (!rst_ni)
    held_v |-> bank_q == held_q);
endmodule

// File: rtl/bank_zero_det.sv
module bank_zero_det #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [W-1:0] bank_i,
  output logic         zero_o
);
  logic [SEL_W:0] any_q;
  assign any_q[0] = 1'b0;

  for (genvar g = 0; g < SEL_W; g++) begin : g_or
    assign any_q[g+1] = any_q[g] | bank_i[g];
  end

  assign zero_o = ~any_q[SEL_W];

  logic unused_hi;
  assign unused_hi = ^bank_i[W-1:SEL_W];
endmodule

// File: rtl/region_decode.sv
module region_decode
  import bank_decoder_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          rst_ni,
  input  logic          phi2_i,
  input  logic          bank_zero_i,
  input  logic [AW-1:0] addr_i,
  input  logic          valid_i,
  output sel_t          sel_o,
  output logic          wait_o
);
  region_e region;
  logic    hi_window;

  assign hi_window = bank_zero_i & addr_i[AW-1] & addr_i[AW-2];

  always_comb begin
    region = REG_RAM;
    if (hi_window) begin
      if (addr_i[AW-1:AW-4] == IO_NIBBLE) region = REG_IO;
      else                                region = REG_ROM;
    end
  end

  always_comb begin
    sel_o = '0;
    if (valid_i) begin
      unique case (region)
        REG_IO:  begin
          sel_o.io_lo = ~addr_i[IO_SPLIT_BIT];
          sel_o.io_hi =  addr_i[IO_SPLIT_BIT];
        end
        REG_ROM: sel_o.rom = 1'b1;
        default: sel_o.ram = 1'b1;
      endcase
    end
  end

  assign wait_o = valid_i & (region != REG_RAM);

  p_onehot_sel_r9: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  p_idle_quiet_r9: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    !valid_i |-> (sel_o == '0 && !wait_o));
  p_slow_only_bank0_r3: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    !bank_zero_i |-> !(sel_o.io_lo || sel_o.io_hi || sel_o.rom));
  p_wait_has_sel_r8: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    wait_o |-> (sel_o.io_lo || sel_o.io_hi || sel_o.rom));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_decoder_pkg::*;
(
  input  logic                  rst_ni,
  input  logic                  phi2_i,
  input  logic [BANK_W-1:0]     data_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  vda_i,
  input  logic                  vpa_i,
  output logic                  bank_zero_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_cs_o,
  output logic                  io_lo_cs_o,
  output logic                  io_hi_cs_o,
  output logic                  rom_cs_o,
  output logic                  wait_req_o
);
  logic [BANK_W-1:0] bank;
  logic              bank_zero;
  sel_t              sel;

  bank_latch #(.W(BANK_W)) u_latch (
    .rst_ni (rst_ni),
    .phi2_i (phi2_i),
    .data_i (data_i),
    .bank_o (bank)
  );

  bank_zero_det #(.W(BANK_W), .SEL_W(BANK_SEL_W)) u_zero (
    .bank_i (bank),
    .zero_o (bank_zero)
  );

  region_decode #(.AW(ADDR_W)) u_dec (
    .rst_ni      (rst_ni),
    .phi2_i      (phi2_i),
    .bank_zero_i (bank_zero),
    .addr_i      (addr_i),
    .valid_i     (vda_i | vpa_i),
    .sel_o       (sel),
    .wait_o      (wait_req_o)
  );

  assign bank_zero_o = bank_zero;
  assign ram_addr_o  = {bank[BANK_SEL_W-1:0], addr_i};
  assign ram_cs_o    = sel.ram;
  assign io_lo_cs_o  = sel.io_lo;
  assign io_hi_cs_o  = sel.io_hi;
  assign rom_cs_o    = sel.rom;

  p_ram_addr_r7: assert property (@(posedge phi2_i) disable iff (!rst_ni)
    ram_addr_o[ADDR_W-1:0] == addr_i);
endmodule

// File: tb/bank_decoder_tb_top.sv
`timescale 1ns/1ps
module bank_decoder_tb_top;
  logic        rst_ni = 1'b0;
  logic        phi2   = 1'b0;
  logic [7:0]  data   = 8'h55;
  logic [15:0] addr   = '0;
  logic        vda = 1'b0, vpa = 1'b0;
  logic        bz, ram, iol, ioh, rom, wt;
  logic [18:0] ra;
  int          n_chk = 0, n_bad = 0;

  always #2 phi2 = ~phi2;

  bank_decoder dut_i (
    .rst_ni(rst_ni), .phi2_i(phi2), .data_i(data), .addr_i(addr),
    .vda_i(vda), .vpa_i(vpa), .bank_zero_o(bz), .ram_addr_o(ra),
    .ram_cs_o(ram), .io_lo_cs_o(iol), .io_hi_cs_o(ioh), .rom_cs_o(rom),
    .wait_req_o(wt)
  );

  // {bank, addr, vda, vpa, ram, io_lo, io_hi, rom, wait, bank_zero}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 16'h0000, 2'b10, 4'b1000, 1'b0, 1'b1},
    {8'h00, 16'hBFFF, 2'b10, 4'b1000, 1'b0, 1'b1},
    {8'h00, 16'hC000, 2'b10, 4'b0100, 1'b1, 1'b1},
    {8'h00, 16'hC3FF, 2'b01, 4'b0100, 1'b1, 1'b1},
    {8'h00, 16'hC400, 2'b10, 4'b0010, 1'b1, 1'b1},
    {8'h00, 16'hC7FF, 2'b10, 4'b0010, 1'b1, 1'b1},
    {8'h00, 16'hC800, 2'b10, 4'b0100, 1'b1, 1'b1},
    {8'h00, 16'hCC00, 2'b11, 4'b0010, 1'b1, 1'b1},
    {8'h00, 16'hD000, 2'b10, 4'b0001, 1'b1, 1'b1},
    {8'h00, 16'hFFFF, 2'b01, 4'b0001, 1'b1, 1'b1},
    {8'h01, 16'hC000, 2'b10, 4'b1000, 1'b0, 1'b0},
    {8'h07, 16'hFFFF, 2'b10, 4'b1000, 1'b0, 1'b0},
    {8'h03, 16'hE000, 2'b11, 4'b1000, 1'b0, 1'b0},
    {8'h08, 16'hD000, 2'b10, 4'b0001, 1'b1, 1'b1},
    {8'hF8, 16'hC400, 2'b10, 4'b0010, 1'b1, 1'b1},
    {8'h40, 16'hFFFF, 2'b01, 4'b0001, 1'b1, 1'b1},
    {8'h00, 16'hC000, 2'b00, 4'b0000, 1'b0, 1'b1},
    {8'h05, 16'h8000, 2'b00, 4'b0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: bank in low phase, junk on data during high phase
  task automatic cycle(input logic [7:0] b, input logic [15:0] a, input logic [1:0] v);
    @(negedge phi2);
    #0.5;
    data = b; addr = a; {vda, vpa} = v;
    @(posedge phi2);
    #1 data = ~b;
    #0.5;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset clears latch even with phase-2 low and bus active
    #1;
    chk("R10 bank_zero in reset", 32'(bz), 32'd1);
    chk("R10 ram bank in reset", 32'(ra[18:16]), 32'd0);
    @(posedge phi2); #0.5 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  b;
      logic [15:0] a;
      logic [1:0]  v;
      logic [3:0]  s;
      logic        w, z;
      {b, a, v, s, w, z} = VEC[i];
      cycle(b, a, v);
      // R4 R5 R6 R9: selects; R2: data already changed
      chk("R4/R5/R6/R9 selects", 32'({ram, iol, ioh, rom}), 32'(s));
      chk("R8 wait", 32'(wt), 32'(w));
      chk("R3 bank_zero", 32'(bz), 32'(z));
      chk("R7 ram_addr", 32'(ra), 32'({b[2:0], a}));
    end

    // R1: transparency within one low phase
    @(negedge phi2);
    #0.3 data = 8'h02;
    #0.5 chk("R1 follow 02", 32'(ra[18:16]), 32'd2);
    data = 8'h06;
    #0.5 chk("R1 follow 06", 32'(ra[18:16]), 32'd6);
    // R2: hold through high phase while bus toggles
    @(posedge phi2);
    #0.5 data = 8'h00;
    #0.5 chk("R2 hold bank", 32'(ra[18:16]), 32'd6);
    chk("R2 hold bank_zero", 32'(bz), 32'd0);
    data = 8'hFF;
    #0.5 chk("R2 hold again", 32'(ra[18:16]), 32'd6);

    // R10: reset mid-run returns to bank zero
    @(negedge phi2);
    #0.5 data = 8'h07; rst_ni = 1'b0;
    #0.5 chk("R10 async clear", 32'(ra[18:16]), 32'd0);
    @(posedge phi2); #0.5 rst_ni = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule